// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block keeps uncommitted instructions in program order, in a circular store with a head pointer and a tail pointer. An instruction that issues takes the slot at the tail and gets that slot's index back as its tag. Execution units later post their results against the tag through a writeback port. Each writeback carries the result value, a fault flag and, for branches, a misprediction flag. Dependent instructions can read a finished but not yet retired value by tag through a lookup port.

Retirement takes place only at the head, and at most one entry retires per cycle. A finished head entry writes its value to the register file. If the entry is a store, it releases its value to memory instead. A fault is held silently in its entry until that entry reaches the head. It then raises a one-cycle trap that carries the entry's PC, and it discards the whole buffer. A branch that reaches the head marked as mispredicted retires and discards every younger entry. Younger results are therefore never seen by the architectural state.

Top module: `retire_queue`

## Requirements
- R1: After reset the buffer is empty: `iss_ready`=1, `iss_tag`=0, `rd_hit`=0, and `reg_we`, `mem_we`, `retire_valid`, `trap_valid` and `squash` are all 0.
- R2: An accepted issue (`iss_valid` and `iss_ready` both high) takes the slot named by `iss_tag`. The tag then advances by one, modulo DEPTH.
- R3: Once DEPTH entries are held, `iss_ready` is 0. An issue offered then is dropped and `iss_tag` does not move.
- R4: A writeback to a held entry marks it finished. From the next cycle, `rd_hit`=1 and `rd_value` returns the written value for that tag. An entry that has not been written back gives `rd_hit`=0.
- R5: Only the head entry may retire, and only once it is finished. A finished younger entry waits. A kind 00 (ALU) or 01 (load) entry retires with `reg_we`=1 and puts its destination and value on `reg_dest`/`reg_value`.
- R6: A finished kind 10 (store) entry at the head retires with `mem_we`=1 and `mem_value` equal to its value. `reg_we` stays 0.
- R7: A kind 11 (branch) entry retires with `retire_valid`=1 and no write. If it was written back with `wb_mispredict`=1, `squash` pulses in that cycle and all younger entries are dropped. The next `iss_tag` is then the slot after the branch.
- R8: A fault written back raises nothing until its entry is the finished head. Then `trap_valid`=1 for one cycle with `trap_pc` equal to the entry's PC. No write occurs, `squash`=1, the buffer empties, and the next `iss_tag` is the faulting slot.
- R9: A writeback whose tag names a slot not currently held is ignored. A later lookup of that tag gives `rd_hit`=0.
- R10: An issue, a writeback and a retirement may all take effect in the same cycle.
- R11: In any cycle at most one of `reg_we`, `mem_we` and `trap_valid` is high.
- R12: In a cycle with `squash`=1, `iss_ready` is 0, so no issue is lost to the discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_kind | input | 2 | 00 ALU, 01 load, 10 store, 11 branch |
| iss_dest | input | AREG | Destination register of the issuing instruction |
| iss_pc | input | PCW | PC of the issuing instruction |
| iss_ready | output | 1 | Buffer can accept an issue this cycle |
| iss_tag | output | IDXW | Slot given to the issuing instruction |
| wb_valid | input | 1 | Writeback present |
| wb_tag | input | IDXW | Slot being written back |
| wb_value | input | XLEN | Result or store data |
| wb_fault | input | 1 | Instruction raised a fault |
| wb_mispredict | input | 1 | Branch was mispredicted |
| rd_tag | input | IDXW | Operand lookup tag |
| rd_hit | output | 1 | Looked-up slot holds a finished result |
| rd_value | output | XLEN | Looked-up result (zero on miss) |
| retire_valid | output | 1 | An entry leaves the head normally this cycle |
| reg_we | output | 1 | Register file write |
| reg_dest | output | AREG | Register file write index |
| reg_value | output | XLEN | Register file write data |
| mem_we | output | 1 | Store released to memory |
| mem_value | output | XLEN | Store data |
| trap_valid | output | 1 | Precise trap at the head |
| trap_pc | output | PCW | PC of the trapping instruction |
| squash | output | 1 | Buffer contents discarded this cycle |

## Verification
The hardest state to reach from the ports is a full buffer whose head finishes while issue and writeback traffic continues around it. The bench gets there with a random phase in which writebacks are rare, so the buffer fills, followed by a phase in which they are frequent. A directed sequence also fills the buffer and then releases the head one step at a time. A fault parked behind a finished older entry is a second hard case. A misprediction that lands while younger results are already finished is a third. Both are set up in directed sequences, and random writebacks with fault and mispredict flags cover further mixes.

// File: rtl/retire_pkg.sv
package retire_pkg;

    typedef enum logic [1:0] {
        KIND_ALU    = 2'b00,
        KIND_LOAD   = 2'b01,
        KIND_STORE  = 2'b10,
        KIND_BRANCH = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_RETIRE,
        ACT_TRAP,
        ACT_REDIRECT
    } head_act_e;

endpackage

// File: rtl/retire_head_eval.sv
module retire_head_eval
    import retire_pkg::*;
(
    input  logic      vld,
    input  logic      rdy,
    input  logic      flt,
    input  logic      bad,
    input  kind_e     kind,
    output head_act_e act
);
    // Faults take precedence over redirects; nothing happens until finished.
    always_comb begin
        act = ACT_HOLD;
        if (vld && rdy) begin
            if (flt)
                act = ACT_TRAP;
            else if (kind == KIND_BRANCH && bad)
                act = ACT_REDIRECT;
            else
                act = ACT_RETIRE;
        end
    end
endmodule

// File: rtl/retire_lookup.sv
module retire_lookup #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]           vld,
    input  logic [DEPTH-1:0]           rdy,
    input  logic [DEPTH-1:0][XLEN-1:0] val,
    input  logic [IDXW-1:0]            tag,
    output logic                       hit,
    output logic [XLEN-1:0]            value
);
    logic [DEPTH-1:0] avail;

    for (genvar g = 0; g < DEPTH; g++) begin : g_avail
        assign avail[g] = vld[g] & rdy[g];
    end

    assign hit   = avail[tag];
    assign value = hit ? val[tag] : '0;
endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import retire_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    parameter int AREG  = 5,
    parameter int PCW   = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iss_valid,
    input  logic [1:0]      iss_kind,
    input  logic [AREG-1:0] iss_dest,
    input  logic [PCW-1:0]  iss_pc,
    output logic            iss_ready,
    output logic [IDXW-1:0] iss_tag,
    input  logic            wb_valid,
    input  logic [IDXW-1:0] wb_tag,
    input  logic [XLEN-1:0] wb_value,
    input  logic            wb_fault,
    input  logic            wb_mispredict,
    input  logic [IDXW-1:0] rd_tag,
    output logic            rd_hit,
    output logic [XLEN-1:0] rd_value,
    output logic            retire_valid,
    output logic            reg_we,
    output logic [AREG-1:0] reg_dest,
    output logic [XLEN-1:0] reg_value,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_value,
    output logic            trap_valid,
    output logic [PCW-1:0]  trap_pc,
    output logic            squash
);
    localparam int PTRW = IDXW + 1;  // extra wrap bit separates full from empty

    typedef struct packed {
        logic [PTRW-1:0]            head;
        logic [PTRW-1:0]            tail;
        logic [DEPTH-1:0]           vld;
        logic [DEPTH-1:0]           rdy;
        logic [DEPTH-1:0]           flt;
        logic [DEPTH-1:0]           bad;
        logic [DEPTH-1:0][XLEN-1:0] val;
        logic [DEPTH-1:0][AREG-1:0] dst;
        logic [DEPTH-1:0][PCW-1:0]  pc;
        logic [DEPTH-1:0][1:0]      kind;
    } state_t;

    state_t s_d, s_q;

    logic [IDXW-1:0] head_idx, tail_idx;
    logic            full_w, accept_w;
    head_act_e       head_act;
    kind_e           head_kind;

    assign head_idx  = s_q.head[IDXW-1:0];
    assign tail_idx  = s_q.tail[IDXW-1:0];
    assign full_w    = (head_idx == tail_idx) && (s_q.head[IDXW] != s_q.tail[IDXW]);
    assign head_kind = kind_e'(s_q.kind[head_idx]);

    retire_head_eval u_eval (
        .vld  (s_q.vld[head_idx]),
        .rdy  (s_q.rdy[head_idx]),
        .flt  (s_q.flt[head_idx]),
        .bad  (s_q.bad[head_idx]),
        .kind (head_kind),
        .act  (head_act)
    );

    retire_lookup #(.DEPTH(DEPTH), .XLEN(XLEN)) u_lookup (
        .vld   (s_q.vld),
        .rdy   (s_q.rdy),
        .val   (s_q.val),
        .tag   (rd_tag),
        .hit   (rd_hit),
        .value (rd_value)
    );

    assign squash   = (head_act == ACT_TRAP) || (head_act == ACT_REDIRECT);
    assign accept_w = iss_valid && !full_w && !squash;

    always_comb begin
        s_d = s_q;
        if (squash) begin
            s_d.vld = '0;
            s_d.rdy = '0;
            if (head_act == ACT_REDIRECT)
                s_d.head = s_q.head + PTRW'(1);
            s_d.tail = s_d.head;
        end else begin
            if (wb_valid && s_q.vld[wb_tag]) begin
                s_d.rdy[wb_tag] = 1'b1;
                s_d.val[wb_tag] = wb_value;
                s_d.flt[wb_tag] = wb_fault;
                s_d.bad[wb_tag] = wb_mispredict;
            end
            if (head_act == ACT_RETIRE) begin
                s_d.vld[head_idx] = 1'b0;
                s_d.rdy[head_idx] = 1'b0;
                s_d.head          = s_q.head + PTRW'(1);
            end
            if (accept_w) begin
                s_d.vld[tail_idx]  = 1'b1;
                s_d.rdy[tail_idx]  = 1'b0;
                s_d.flt[tail_idx]  = 1'b0;
                s_d.bad[tail_idx]  = 1'b0;
                s_d.dst[tail_idx]  = iss_dest;
                s_d.pc[tail_idx]   = iss_pc;
                s_d.kind[tail_idx] = iss_kind;
                s_d.tail           = s_q.tail + PTRW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign iss_ready    = !full_w && !squash;
    assign iss_tag      = tail_idx;
    assign retire_valid = (head_act == ACT_RETIRE) || (head_act == ACT_REDIRECT);
    assign reg_we       = (head_act == ACT_RETIRE) &&
                          (head_kind == KIND_ALU || head_kind == KIND_LOAD);
    assign reg_dest     = s_q.dst[head_idx];
    assign reg_value    = s_q.val[head_idx];
    assign mem_we       = (head_act == ACT_RETIRE) && (head_kind == KIND_STORE);
    assign mem_value    = s_q.val[head_idx];
    assign trap_valid   = (head_act == ACT_TRAP);
    assign trap_pc      = s_q.pc[head_idx];
endmodule

// File: rtl/retire_queue_chk.sv
module retire_queue_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            iss_valid,
    input logic            iss_ready,
    input logic [IDXW-1:0] iss_tag,
    input logic            retire_valid,
    input logic            reg_we,
    input logic            mem_we,
    input logic            trap_valid,
    input logic            squash
);
    assert_one_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, mem_we, trap_valid}));

    assert_write_is_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || mem_we) |-> retire_valid);

    assert_trap_discards_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (squash && !retire_valid));

    assert_quiet_after_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (!squash && !trap_valid && !retire_valid && iss_ready));

    assert_no_issue_on_squash_R12: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !iss_ready);

    assert_tag_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> (iss_tag == $past(iss_tag) + IDXW'(1)));
endmodule

bind retire_queue retire_queue_chk #(.IDXW(IDXW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_ready    (iss_ready),
    .iss_tag      (iss_tag),
    .retire_valid (retire_valid),
    .reg_we       (reg_we),
    .mem_we       (mem_we),
    .trap_valid   (trap_valid),
    .squash       (squash)
);

// File: tb/sim_retire_queue.sv
module sim_retire_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int XLEN  = 32;
    localparam int AREG  = 5;
    localparam int PCW   = 32;
    localparam int IDXW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            iss_valid = 1'b0;
    logic [1:0]      iss_kind = '0;
    logic [AREG-1:0] iss_dest = '0;
    logic [PCW-1:0]  iss_pc = '0;
    logic            iss_ready;
    logic [IDXW-1:0] iss_tag;
    logic            wb_valid = 1'b0;
    logic [IDXW-1:0] wb_tag = '0;
    logic [XLEN-1:0] wb_value = '0;
    logic            wb_fault = 1'b0;
    logic            wb_mispredict = 1'b0;
    logic [IDXW-1:0] rd_tag = '0;
    logic            rd_hit;
    logic [XLEN-1:0] rd_value;
    logic            retire_valid, reg_we, mem_we, trap_valid, squash;
    logic [AREG-1:0] reg_dest;
    logic [XLEN-1:0] reg_value, mem_value;
    logic [PCW-1:0]  trap_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    retire_queue #(.DEPTH(DEPTH), .XLEN(XLEN), .AREG(AREG), .PCW(PCW)) u0 (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model of the buffer
    bit              m_vld [DEPTH];
    bit              m_rdy [DEPTH];
    bit              m_flt [DEPTH];
    bit              m_bad [DEPTH];
    logic [XLEN-1:0] m_val [DEPTH];
    logic [AREG-1:0] m_dst [DEPTH];
    logic [PCW-1:0]  m_pc  [DEPTH];
    logic [1:0]      m_kind[DEPTH];
    int              m_head = 0;
    int              m_tail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic int held();
        return (m_tail - m_head + 2*DEPTH) % (2*DEPTH);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_vld[i] = 0; m_rdy[i] = 0; m_flt[i] = 0; m_bad[i] = 0;
            m_val[i] = '0; m_dst[i] = '0; m_pc[i] = '0; m_kind[i] = '0;
        end
        m_head = 0;
        m_tail = 0;
    endtask

    task automatic idle_inputs();
        iss_valid = 0; wb_valid = 0; wb_fault = 0; wb_mispredict = 0;
    endtask

    // compare all outputs against the model, then advance one clock
    task automatic tick();
        int  h, t;
        bit  e_trap, e_redir, e_ret, e_sq, e_rdy, e_hit;
        #1;
        h = m_head % DEPTH;
        t = m_tail % DEPTH;
        e_trap  = m_vld[h] && m_rdy[h] && m_flt[h];
        e_redir = m_vld[h] && m_rdy[h] && !m_flt[h] && m_kind[h] == 2'b11 && m_bad[h];
        e_ret   = m_vld[h] && m_rdy[h] && !m_flt[h] && !e_redir;
        e_sq    = e_trap || e_redir;
        e_rdy   = (held() != DEPTH) && !e_sq;
        e_hit   = m_vld[rd_tag] && m_rdy[rd_tag];

        chk(iss_ready == e_rdy, "R3 iss_ready", iss_ready, e_rdy);
        chk(iss_tag == IDXW'(t), "R2 iss_tag", iss_tag, t);
        chk(rd_hit == e_hit, "R4 rd_hit", rd_hit, e_hit);
        if (e_hit) chk(rd_value == m_val[rd_tag], "R4 rd_value", rd_value, m_val[rd_tag]);
        chk(reg_we == (e_ret && !m_kind[h][1]), "R5 reg_we", reg_we, e_ret && !m_kind[h][1]);
        if (reg_we) begin
            chk(reg_dest == m_dst[h], "R5 reg_dest", reg_dest, m_dst[h]);
            chk(reg_value == m_val[h], "R5 reg_value", reg_value, m_val[h]);
        end
        chk(mem_we == (e_ret && m_kind[h] == 2'b10), "R6 mem_we", mem_we, e_ret && m_kind[h] == 2'b10);
        if (mem_we) chk(mem_value == m_val[h], "R6 mem_value", mem_value, m_val[h]);
        chk(retire_valid == (e_ret || e_redir), "R7 retire_valid", retire_valid, e_ret || e_redir);
        chk(squash == e_sq, "R7 squash", squash, e_sq);
        chk(trap_valid == e_trap, "R8 trap_valid", trap_valid, e_trap);
        if (e_trap) chk(trap_pc == m_pc[h], "R8 trap_pc", trap_pc, m_pc[h]);
        chk($countones({reg_we, mem_we, trap_valid}) <= 1, "R11 exclusive", {reg_we, mem_we, trap_valid}, 0);
        if (squash) chk(!iss_ready, "R12 no issue on squash", iss_ready, 0);

        if (e_sq) begin
            for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_rdy[i] = 0; end
            if (e_redir) m_head = (m_head + 1) % (2*DEPTH);
            m_tail = m_head;
        end else begin
            if (wb_valid && m_vld[wb_tag]) begin
                m_rdy[wb_tag] = 1; m_val[wb_tag] = wb_value;
                m_flt[wb_tag] = wb_fault; m_bad[wb_tag] = wb_mispredict;
            end
            if (e_ret) begin
                m_vld[h] = 0; m_rdy[h] = 0;
                m_head = (m_head + 1) % (2*DEPTH);
            end
            if (iss_valid && e_rdy) begin
                m_vld[t] = 1; m_rdy[t] = 0; m_flt[t] = 0; m_bad[t] = 0;
                m_dst[t] = iss_dest; m_pc[t] = iss_pc; m_kind[t] = iss_kind;
                m_tail = (m_tail + 1) % (2*DEPTH);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic issue(input logic [1:0] k, input int d, input int p);
        idle_inputs();
        iss_valid = 1; iss_kind = k; iss_dest = AREG'(d); iss_pc = PCW'(p);
        tick();
    endtask

    task automatic wback(input int tg, input int v, input bit f, input bit b);
        idle_inputs();
        wb_valid = 1; wb_tag = IDXW'(tg); wb_value = XLEN'(v); wb_fault = f; wb_mispredict = b;
        tick();
    endtask

    task automatic rand_run(input int n, input int wb_pct, input int iss_pct);
        for (int i = 0; i < n; i++) begin
            iss_valid     = ($urandom % 100) < iss_pct;
            iss_kind      = 2'($urandom);
            iss_dest      = AREG'($urandom);
            iss_pc        = PCW'($urandom);
            wb_valid      = ($urandom % 100) < wb_pct;
            wb_tag        = IDXW'($urandom);
            wb_value      = $urandom;
            wb_fault      = ($urandom % 25) == 0;
            wb_mispredict = ($urandom % 6) == 0;
            rd_tag        = IDXW'($urandom);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();

        // R1: reset state
        #1;
        chk(iss_ready == 1 && iss_tag == 0, "R1 ready/tag", {iss_ready, iss_tag}, 4'b1000);
        chk({reg_we, mem_we, retire_valid, trap_valid, squash, rd_hit} == 0, "R1 outputs idle",
            {reg_we, mem_we, retire_valid, trap_valid, squash, rd_hit}, 0);
        tick();

        // R3: fill the buffer with no writebacks
        for (int i = 0; i < DEPTH; i++) issue(2'b00, i + 1, 32'h100 + 4*i);
        idle_inputs(); iss_valid = 1; #1;
        chk(iss_ready == 0, "R3 full stalls", iss_ready, 0);
        tick();
        #1;
        chk(iss_tag == 0, "R3 dropped issue keeps tag", iss_tag, 0);

        // R4/R5: younger result finished, head not: lookup hits, no retire
        wback(5, 32'h55, 0, 0);
        idle_inputs(); rd_tag = 5; #1;
        chk(rd_hit == 1 && rd_value == 32'h55, "R4 lookup finished", rd_value, 32'h55);
        chk(reg_we == 0, "R5 younger waits", reg_we, 0);
        tick();
        rd_tag = 6; #1;
        chk(rd_hit == 0, "R4 unfinished misses", rd_hit, 0);
        tick();

        // R10: release head while full, then issue+writeback+retire together
        wback(0, 32'hA0, 0, 0);
        idle_inputs(); #1;
        chk(reg_we == 1 && reg_dest == 1, "R5 head retires", reg_dest, 1);
        tick();
        wback(1, 32'hA1, 0, 0);
        idle_inputs();
        iss_valid = 1; iss_kind = 2'b01; iss_dest = 5'd9; iss_pc = 32'h400;
        wb_valid = 1; wb_tag = 2; wb_value = 32'hA2;
        #1;
        chk(reg_we && iss_ready && wb_valid && iss_tag == 0, "R10 concurrent", {reg_we, iss_ready, iss_tag}, 5'b11000);
        tick();
        idle_inputs(); rd_tag = 2; #1;
        chk(rd_hit == 1 && rd_value == 32'hA2, "R10 writeback landed", rd_value, 32'hA2);
        tick();

        // R9: writeback to a slot not held
        do_reset();
        issue(2'b00, 1, 32'h10);
        issue(2'b00, 2, 32'h14);
        wback(5, 32'h99, 0, 0);
        idle_inputs(); rd_tag = 5; #1;
        chk(rd_hit == 0, "R9 ignored writeback", rd_hit, 0);
        tick();
        for (int i = 0; i < 4; i++) issue(2'b00, 3 + i, 32'h18 + 4*i);
        idle_inputs(); rd_tag = 5; #1;
        chk(rd_hit == 0, "R9 slot stays unfinished", rd_hit, 0);
        tick();

        // R6/R7: store then mispredicted branch with finished younger entries
        do_reset();
        issue(2'b10, 0, 32'h200);
        issue(2'b11, 0, 32'h204);
        issue(2'b00, 7, 32'h208);
        issue(2'b00, 8, 32'h20C);
        wback(3, 32'h33, 0, 0);
        wback(2, 32'h22, 0, 0);
        wback(1, 32'h0, 0, 1);
        wback(0, 32'h5A, 0, 0);
        idle_inputs(); #1;
        chk(mem_we == 1 && mem_value == 32'h5A && reg_we == 0, "R6 store release", mem_value, 32'h5A);
        tick();
        idle_inputs(); iss_valid = 1; #1;
        chk(squash == 1 && retire_valid == 1 && reg_we == 0, "R7 mispredict squash", {squash, retire_valid, reg_we}, 3'b110);
        chk(iss_ready == 0, "R12 issue blocked", iss_ready, 0);
        tick();
        idle_inputs(); rd_tag = 2; #1;
        chk(rd_hit == 0 && iss_tag == 2, "R7 younger dropped", {rd_hit, iss_tag}, 4'b0010);
        tick();

        // R8: fault parked behind a finished older entry
        issue(2'b00, 4, 32'h300);
        issue(2'b01, 5, 32'h304);
        wback(3, 32'h77, 1, 0);
        idle_inputs(); #1;
        chk(trap_valid == 0, "R8 fault held", trap_valid, 0);
        tick();
        wback(2, 32'h66, 0, 0);
        idle_inputs(); #1;
        chk(reg_we == 1 && reg_dest == 4, "R8 older commits first", reg_dest, 4);
        tick();
        idle_inputs(); #1;
        chk(trap_valid == 1 && trap_pc == 32'h304 && reg_we == 0, "R8 trap at head", trap_pc, 32'h304);
        tick();
        idle_inputs(); #1;
        chk(trap_valid == 0 && iss_tag == 3, "R8 one-cycle trap, tag at fault slot", {trap_valid, iss_tag}, 4'b0011);
        tick();

        // random traffic: balanced, then starved writebacks, then heavy writebacks
        rand_run(600, 40, 60);
        rand_run(400, 5, 90);
        rand_run(600, 80, 50);
        idle_inputs();
        tick();

        report();
    end
endmodule